// File: doc/BRIEF.md
# Lockable Boundary Test Wrapper Chain

This block is a serial chain of boundary wrapper cells placed around the functional inputs and outputs of a core. Each input cell sits between the surrounding logic and a core input. Each output cell sits between a core output and the surrounding logic. Every cell holds one storage bit. The bits are linked into a single scan path that starts at `scan_in`, runs through the input cells and then the output cells, and ends at `scan_out`.

A two-bit mode code selects what drives the functional outputs:
- In pass-through mode, the functional outputs simply follow the functional inputs.
- In the two test modes, the cell bits drive the core inputs and the surrounding logic. This lets test vectors reach the core, or reach the logic around the core while the core is cut off.

A separate safe control forces every functional output to one chosen level.

Capture and shift act only when the external `unlock` input is high. That input comes from a challenge-response check outside this block. While it is low, the cells keep their contents, the scan input is ignored and the scan output reads 0. A locked wrapper therefore neither loads nor reveals any core data.

Top module: `lockable_wrapper_chain`

## Requirements
- R1: An active-low asynchronous `rst_n` clears every cell bit to 0.
- R2: When `unlock` and `shift_en` are both high at a rising clock edge, input cell 0 takes `scan_in`. Each later cell takes the previous cell's value, in the order input cells 0..N_IN-1 and then output cells 0..N_OUT-1.
- R3: `scan_out` equals the last output cell's bit whenever `unlock` is high.
- R4: When `unlock` and `capture_en` are high and `shift_en` is low at a rising edge, each input cell loads its `sys_in` bit and each output cell loads its `core_out` bit.
- R5: When both `shift_en` and `capture_en` are high, the chain shifts and does not capture.
- R6: With neither enable high, every cell holds its value.
- R7: While `unlock` is low, shift and capture have no effect on the cells and `scan_out` is 0.
- R8: Mode 2'b00 (normal) and the spare code 2'b11 pass `sys_in` to `core_in` and `core_out` to `sys_out`.
- R9: Mode 2'b01 (internal test) and 2'b10 (external test) drive `core_in` from the input cells and `sys_out` from the output cells.
- R10: While `safe_ctl` is high, every bit of `core_in` and `sys_out` equals `safe_val`, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock for the cell bits |
| rst_n | input | 1 | Asynchronous active-low reset |
| unlock | input | 1 | Access grant from the challenge-response check |
| mode | input | 2 | Mode code: 00 normal, 01 internal test, 10 external test, 11 normal |
| shift_en | input | 1 | Shift request |
| capture_en | input | 1 | Capture request |
| safe_ctl | input | 1 | Force functional outputs to the safe level |
| safe_val | input | 1 | Safe level |
| scan_in | input | 1 | Serial test data in |
| scan_out | output | 1 | Serial test data out |
| sys_in | input | N_IN | Functional inputs from the surrounding logic |
| core_in | output | N_IN | Functional inputs driven into the core |
| core_out | input | N_OUT | Functional outputs from the core |
| sys_out | output | N_OUT | Functional outputs to the surrounding logic |

## Verification
The bench builds the chain with three input cells and two output cells. At that size, a full pass of the scan path takes five shifts. Every cell bit also appears on a port in the test modes, so the contents are visible after each step. Under that configuration, the bench checks that locking leaves those visible bits unchanged, that data moves across the boundary between the input and output groups, and that the spare mode code behaves as normal mode.

// File: rtl/lockable_wrapper_chain.sv
module lockable_wrapper_chain #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unlock,
  input  logic [1:0]       mode,
  input  logic             shift_en,
  input  logic             capture_en,
  input  logic             safe_ctl,
  input  logic             safe_val,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_IN-1:0]  sys_in,
  output logic [N_IN-1:0]  core_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [N_OUT-1:0] sys_out
);
  localparam int N = N_IN + N_OUT;

  logic [N-1:0] cells;
  logic         go_shift, go_cap, test_mode;

  assign go_shift  = unlock & shift_en;
  assign go_cap    = unlock & capture_en;
  assign test_mode = (mode == 2'b01) || (mode == 2'b10);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cells <= '0;
    else if (go_shift) cells <= {cells[N-2:0], scan_in};
    else if (go_cap)   cells <= {core_out, sys_in};
  end

  assign core_in  = safe_ctl ? {N_IN{safe_val}}  : (test_mode ? cells[N_IN-1:0] : sys_in);
  assign sys_out  = safe_ctl ? {N_OUT{safe_val}} : (test_mode ? cells[N-1:N_IN] : core_out);
  assign scan_out = unlock & cells[N-1];

  p_shift_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && shift_en) |=> cells[0] == $past(scan_in));

  p_capture_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock && capture_en && !shift_en) |=> cells == {$past(core_out), $past(sys_in)});

  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_en || capture_en) |=> $stable(cells));

  p_locked_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |=> $stable(cells));

  p_locked_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |-> scan_out == 1'b0);

  p_safe_force_r10: assert property (@(posedge clk) disable iff (!rst_n)
    safe_ctl |-> (core_in == {N_IN{safe_val}}) && (sys_out == {N_OUT{safe_val}}));
endmodule

// File: tb/sim_lockable_wrapper_chain.sv
module sim_lockable_wrapper_chain;
  localparam int CLK_P = 10;
  localparam int NI = 3;
  localparam int NO = 2;
  localparam int NT = NI + NO;

  logic clk = 0, rst_n = 0, unlock = 0, shift_en = 0, capture_en = 0;
  logic safe_ctl = 0, safe_val = 0, scan_in = 0, scan_out;
  logic [1:0] mode = 2'b00;
  logic [NI-1:0] sys_in = '0, core_in;
  logic [NO-1:0] core_out = '0, sys_out;

  int total = 0, bad = 0;
  bit mdl[NT];
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  lockable_wrapper_chain #(.N_IN(NI), .N_OUT(NO)) u0 (
    .clk(clk), .rst_n(rst_n), .unlock(unlock), .mode(mode), .shift_en(shift_en),
    .capture_en(capture_en), .safe_ctl(safe_ctl), .safe_val(safe_val),
    .scan_in(scan_in), .scan_out(scan_out), .sys_in(sys_in), .core_in(core_in),
    .core_out(core_out), .sys_out(sys_out));

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit old[NT];
    old = mdl;
    if (!rst_n) begin
      foreach (mdl[i]) mdl[i] = 0;
    end else if (unlock && shift_en) begin
      mdl[0] = scan_in;
      for (int i = 1; i < NT; i++) mdl[i] = old[i-1];
    end else if (unlock && capture_en) begin
      for (int i = 0; i < NI; i++) mdl[i] = sys_in[i];
      for (int j = 0; j < NO; j++) mdl[NI+j] = core_out[j];
    end
  endtask

  task automatic compare(input string tag);
    int e_ci = 0, e_so = 0, e_out;
    bit tm;
    tm = (mode == 2'b01) || (mode == 2'b10);
    for (int i = 0; i < NI; i++) begin
      bit b;
      b = safe_ctl ? safe_val : (tm ? mdl[i] : sys_in[i]);
      e_ci |= int'(b) << i;
    end
    for (int j = 0; j < NO; j++) begin
      bit b;
      b = safe_ctl ? safe_val : (tm ? mdl[NI+j] : core_out[j]);
      e_so |= int'(b) << j;
    end
    e_out = unlock ? int'(mdl[NT-1]) : 0;
    check(tag, "core_in", int'(core_in), e_ci);
    check(tag, "sys_out", int'(sys_out), e_so);
    check(tag, "scan_out", int'(scan_out), e_out);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_P * 20000);
    total++; bad++;
    $display("FAIL watchdog run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 7;
    @(negedge clk);
    mode = 2'b10;
    step("R1 reset");
    rst_n = 1;
    step("R1 after reset");

    // R7: locked shift and capture leave cells alone, scan_out stays 0
    scan_in = 1; shift_en = 1;
    for (int k = 0; k < 4; k++) step("R7 locked shift");
    shift_en = 0; capture_en = 1; sys_in = 3'b111; core_out = 2'b11;
    step("R7 locked capture");
    capture_en = 0;

    // R2/R3: unlocked shift of pattern 1,0,1,1,0
    unlock = 1; shift_en = 1;
    for (int k = 0; k < NT; k++) begin
      scan_in = ((5'b01101 >> k) & 1) != 0;
      step("R2 R3 shift");
    end
    shift_en = 0;

    // R6: hold
    scan_in = 1;
    for (int k = 0; k < 3; k++) step("R6 hold");

    // R4: capture in internal test mode
    mode = 2'b01; sys_in = 3'b101; core_out = 2'b10; capture_en = 1;
    step("R4 capture");
    capture_en = 0; sys_in = 3'b010; core_out = 2'b01;
    step("R4 after capture");

    // R5: both enables -> shift
    shift_en = 1; capture_en = 1; scan_in = 0; sys_in = 3'b111; core_out = 2'b11;
    step("R5 shift priority");
    step("R5 shift priority 2");
    shift_en = 0; capture_en = 0;

    // R8: normal mode and spare code
    mode = 2'b00;
    for (int k = 0; k < 4; k++) begin
      sys_in = 3'(k * 3 + 1); core_out = 2'(k);
      step("R8 normal");
    end
    mode = 2'b11; sys_in = 3'b110; core_out = 2'b01;
    step("R8 spare code");

    // R9: external test mode
    mode = 2'b10; sys_in = 3'b000; core_out = 2'b00;
    step("R9 external test");

    // R10: safe override in each mode
    safe_ctl = 1;
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m); safe_val = 1; step("R10 safe one");
      safe_val = 0; step("R10 safe zero");
    end
    safe_ctl = 0;

    // R7: lock after load, then reveal contents unchanged
    mode = 2'b10; unlock = 0; shift_en = 1; capture_en = 1; scan_in = 1;
    sys_in = 3'b111; core_out = 2'b11;
    for (int k = 0; k < 3; k++) step("R7 locked after load");
    shift_en = 0; capture_en = 0; unlock = 1;
    step("R7 contents kept");

    // mixed traffic
    for (int k = 0; k < 200; k++) begin
      seed = seed * 1103515245 + 12345;
      unlock = seed[16]; shift_en = seed[17]; capture_en = seed[18];
      scan_in = seed[19]; mode = seed[21:20]; safe_ctl = seed[22] & seed[23];
      safe_val = seed[24]; sys_in = seed[27:25]; core_out = seed[29:28];
      step("R2 R4 R5 R6 R7 mixed");
    end

    // R1: reset mid-run
    rst_n = 0; mode = 2'b01; safe_ctl = 0; unlock = 1;
    step("R1 reset again");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule